// File: doc/BRIEF.md
# I2C Target with Transaction Watchdog

This block is the serial front end of a register file. It listens on an I2C bus as a target, at either the 100 kbit/s or the 400 kbit/s rate. Both rates use the same protocol, and the block's only timing requirement is that its system clock oversamples SCL. SCL and SDA are resynchronised into the system clock domain. From the synchronised lines the block finds START, repeated START and STOP conditions. It answers one fixed 7-bit address and pulls SDA low through an output enable, the usual open-drain arrangement. Write transfers set an internal register pointer and then store bytes at successive locations. Read transfers return bytes from successive locations until the controller declines a byte.

A watchdog counts system clock cycles whenever a transfer is open. A START or repeated START reloads it, and a STOP parks it. If it runs out, the protocol engine drops back to idle and pulses `timeout_o`. Any bytes the controller goes on clocking are then neither acknowledged nor stored until the next START. A controller that dies mid-transfer therefore cannot leave the target holding the bus.

Top module: `i2c_tgt_wdog`

## Requirements
- R1: The first byte after a START carries a 7-bit address (MSB first) followed by a direction bit (0 = write, 1 = read). Only address 0x6B is acknowledged, by holding SDA low through the ninth SCL pulse. Any other address is left unacknowledged, and the bytes that follow are ignored until the next START.
- R2: In a write, the first data byte loads the register pointer. Each later byte pulses `reg_we_o` for exactly one cycle with `reg_addr_o` at the pointer and `reg_wdata_o` holding the byte. The pointer then advances by one. Every byte of the write is acknowledged.
- R3: In a read, the byte at the pointer is shifted out MSB first, and the pointer advances by one for each byte fetched. After the controller acknowledges a byte, the next byte follows. After the controller leaves the acknowledge slot high, the target releases SDA and stays silent until the next START.
- R4: A repeated START begins a new address phase and keeps the register pointer. Writing a pointer and then reading after a repeated START returns the data at that pointer.
- R5: A STOP returns the engine to idle and halts the watchdog, so no timeout occurs however long the bus then stays idle.
- R6: Every START and repeated START restarts the watchdog from zero. A transfer made of segments that are each shorter than `TIMEOUT_CYC` completes even when its total length exceeds `TIMEOUT_CYC`.
- R7: If `TIMEOUT_CYC` cycles pass after a START without a STOP or another START, `timeout_o` pulses for exactly one cycle and SDA is released. Further bytes are neither acknowledged nor written until the next START.
- R8: The target turns its SDA drive on only while the synchronised SCL is low.
- R9: During reset `sda_oe_o`, `reg_we_o` and `timeout_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_addr_o | output | PTR_W | Register pointer, used for both read and write |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data at `reg_addr_o`, combinational |
| timeout_o | output | 1 | One-cycle pulse when the watchdog resets the engine |

## Verification
The assertions assume that SCL stays at each level for more cycles than the synchroniser needs to settle. They also assume that SDA changes only while SCL is low, except at START and STOP. Under those conditions, every rise of the drive enable follows a detected SCL fall. The bench drives the bus with quarter-bit phases of ten system clocks and moves SDA only in the SCL-low quarter, apart from deliberate START and STOP conditions. It models the line as a wired AND of its own pull-down and `sda_oe_o`.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WR,
    ST_RD,
    ST_RD_ACK,
    ST_RD_LOAD,
    ST_WAIT
  } state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw, synced, prev_q;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= synced;
  end

  assign scl_o      = synced[0];
  assign sda_o      = synced[1];
  assign scl_rise_o = synced[0] & ~prev_q[0];
  assign scl_fall_o = ~synced[0] & prev_q[0];
  // SDA edge while SCL held high
  assign start_o    = synced[0] & prev_q[0] & prev_q[1] & ~synced[1];
  assign stop_o     = synced[0] & prev_q[0] & ~prev_q[1] & synced[1];
endmodule

// File: rtl/i2ct_wdog.sv
module i2ct_wdog #(
  parameter int TIMEOUT_CYC = 2_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (start_i) begin
      run_q    <= 1'b1;
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (stop_i) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        run_q    <= 1'b0;
        cnt_q    <= '0;
        expire_o <= 1'b1;
      end else begin
        cnt_q    <= cnt_q + 1'b1;
        expire_o <= 1'b0;
      end
    end else begin
      expire_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h6B,
  parameter int         PTR_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              expire_i,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              sda_oe_o,
  output logic              reg_we_o,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o
);
  state_e            st_q;
  logic [2:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              rd_q, first_q, inc_q, ackd_q;
  logic [BYTE_W-1:0] in_byte;

  assign in_byte    = {sh_q[BYTE_W-2:0], sda_i};
  assign reg_addr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      ptr_q       <= '0;
      rd_q        <= 1'b0;
      first_q     <= 1'b0;
      inc_q       <= 1'b0;
      ackd_q      <= 1'b0;
      sda_oe_o    <= 1'b0;
      reg_we_o    <= 1'b0;
      reg_wdata_o <= '0;
    end else begin
      reg_we_o <= 1'b0;
      if (start_i) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
        ackd_q   <= 1'b0;
        inc_q    <= 1'b0;
      end else if (stop_i || expire_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
        ackd_q   <= 1'b0;
        inc_q    <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: if (scl_rise_i) begin
            sh_q  <= in_byte;
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              if (sh_q[6:0] == TGT_ADDR) begin
                rd_q    <= sda_i;
                first_q <= 1'b1;
                st_q    <= ST_ACK;
              end else begin
                st_q <= ST_WAIT;
              end
            end
          end
          ST_WR: if (scl_rise_i) begin
            sh_q  <= in_byte;
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              st_q <= ST_ACK;
              if (first_q) begin
                ptr_q   <= PTR_W'(in_byte);
                first_q <= 1'b0;
              end else begin
                reg_we_o    <= 1'b1;
                reg_wdata_o <= in_byte;
                inc_q       <= 1'b1;
              end
            end
          end
          ST_ACK: if (scl_fall_i) begin
            if (!ackd_q) begin
              sda_oe_o <= 1'b1;
              ackd_q   <= 1'b1;
            end else begin
              ackd_q <= 1'b0;
              inc_q  <= 1'b0;
              cnt_q  <= '0;
              if (rd_q) begin
                sda_oe_o <= ~reg_rdata_i[BYTE_W-1];
                sh_q     <= {reg_rdata_i[BYTE_W-2:0], 1'b0};
                ptr_q    <= ptr_q + 1'b1;
                st_q     <= ST_RD;
              end else begin
                sda_oe_o <= 1'b0;
                if (inc_q) ptr_q <= ptr_q + 1'b1;
                st_q <= ST_WR;
              end
            end
          end
          ST_RD: if (scl_fall_i) begin
            if (cnt_q == 3'd7) begin
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              st_q     <= ST_RD_ACK;
            end else begin
              sda_oe_o <= ~sh_q[BYTE_W-1];
              sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
              cnt_q    <= cnt_q + 3'd1;
            end
          end
          ST_RD_ACK: if (scl_rise_i) begin
            st_q <= sda_i ? ST_WAIT : ST_RD_LOAD;
          end
          ST_RD_LOAD: if (scl_fall_i) begin
            sda_oe_o <= ~reg_rdata_i[BYTE_W-1];
            sh_q     <= {reg_rdata_i[BYTE_W-2:0], 1'b0};
            ptr_q    <= ptr_q + 1'b1;
            cnt_q    <= '0;
            st_q     <= ST_RD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_wdog.sv
module i2c_tgt_wdog
  import i2ct_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h6B,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         TIMEOUT_CYC = 2_500_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              timeout_o
);
  logic scl_sync, sda_sync, scl_rise, scl_fall, bus_start, bus_stop, expire;

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_sync),
    .sda_o      (sda_sync),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2ct_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (bus_start),
    .stop_i   (bus_stop),
    .expire_o (expire)
  );

  i2ct_engine #(.TGT_ADDR(TGT_ADDR), .PTR_W(PTR_W)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_i       (sda_sync),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (bus_start),
    .stop_i      (bus_stop),
    .expire_i    (expire),
    .reg_rdata_i (reg_rdata_i),
    .sda_oe_o    (sda_oe_o),
    .reg_we_o    (reg_we_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o)
  );

  assign timeout_o = expire;
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_sync_i,
  input logic sda_oe_o,
  input logic reg_we_o,
  input logic timeout_o
);
  assert_timeout_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  assert_release_on_timeout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !sda_oe_o);

  assert_we_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_drive_on_low_scl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_sync_i));
endmodule

bind i2c_tgt_wdog i2ct_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_sync_i (scl_sync),
  .sda_oe_o   (sda_oe_o),
  .reg_we_o   (reg_we_o),
  .timeout_o  (timeout_o)
);

// File: tb/i2c_tgt_wdog_tb.sv
module i2c_tgt_wdog_tb;
  localparam int Q    = 10;
  localparam int TOUT = 4000;
  localparam logic [7:0] AW = 8'hD6;
  localparam logic [7:0] AR = 8'hD7;

  typedef struct packed { logic [7:0] ptr; logic [7:0] dat; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'h00, 8'h3C}, '{8'h01, 8'hC3}, '{8'h7F, 8'h00},
    '{8'h80, 8'hFF}, '{8'hFE, 8'h5A}, '{8'hFF, 8'hA5}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_low = 1'b0;
  logic sda_oe, we, tout;
  logic [7:0] addr, wdata, rdata;
  logic [7:0] mem [256];
  wire  sda_line = ~(sda_low | sda_oe);

  int n_vec = 0, n_err = 0, n_to = 0, oe_bad = 0;
  logic prev_oe = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  i2c_tgt_wdog #(.TIMEOUT_CYC(TOUT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_rdata_i(rdata), .timeout_o(tout));

  assign rdata = mem[addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (we) mem[addr] <= wdata;
  end

  always @(posedge clk) if (rst_n && tout) n_to++;

  always @(negedge clk) begin
    if (rst_n && sda_oe && !prev_oe && scl) oe_bad++;
    prev_oe <= sda_oe;
  end

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_low = 1'b0; qw(); scl = 1'b1; qw(); sda_low = 1'b1; qw(); scl = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    sda_low = 1'b1; qw(); scl = 1'b1; qw(); sda_low = 1'b0; qw();
  endtask

  task automatic send(input logic [7:0] b, output int ack);
    for (int i = 7; i >= 0; i--) begin
      sda_low = ~b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    end
    sda_low = 1'b0; qw(); scl = 1'b1; qw(); ack = sda_line ? 0 : 1; qw(); scl = 1'b0; qw();
  endtask

  task automatic recv(input logic nack, output int b);
    logic [7:0] v;
    sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1'b1; qw(); v[i] = sda_line; qw(); scl = 1'b0; qw();
    end
    sda_low = ~nack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw(); sda_low = 1'b0;
    b = int'(v);
  endtask

  task automatic wr_one(string req, input logic [7:0] p, input logic [7:0] d);
    int a;
    i2c_start(); send(AW, a); chk(req, a, 1);
    send(p, a); chk(req, a, 1); send(d, a); chk(req, a, 1);
    i2c_stop();
  endtask

  task automatic rd_one(string req, input logic [7:0] p, output int d);
    int a;
    i2c_start(); send(AW, a); send(p, a);
    i2c_start(); send(AR, a); chk(req, a, 1);
    recv(1'b1, d); i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    int a, d, to0;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk("R9 oe", int'(sda_oe), 0); chk("R9 we", int'(we), 0); chk("R9 tout", int'(tout), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // vector table: R1 R2 R4 write then read back
    foreach (VECS[k]) begin
      wr_one("R2 vec", VECS[k].ptr, VECS[k].dat);
      rd_one("R4 vec", VECS[k].ptr, d);
      chk("R3 vec data", d, int'(VECS[k].dat));
    end

    // R1 wrong address ignored
    i2c_start(); send(8'hD4, a); chk("R1 no ack addr", a, 0);
    send(8'h30, a); chk("R1 no ack data", a, 0); send(8'hEE, a); i2c_stop();
    rd_one("R1", 8'h30, d); chk("R1 untouched", d, 8'h95);

    // R2 burst with auto-increment, R3 burst read ending on NACK
    i2c_start(); send(AW, a); send(8'h10, a);
    send(8'h11, a); chk("R2 b0", a, 1); send(8'h22, a); chk("R2 b1", a, 1);
    send(8'h33, a); chk("R2 b2", a, 1);
    i2c_start(); send(AW, a); send(8'h10, a);
    i2c_start(); send(AR, a); chk("R4 ack", a, 1);
    recv(1'b0, d); chk("R3 r0", d, 8'h11);
    recv(1'b0, d); chk("R3 r1", d, 8'h22);
    recv(1'b1, d); chk("R3 r2", d, 8'h33);
    repeat (Q) @(negedge clk);
    chk("R3 silent after nack", int'(sda_oe), 0);
    i2c_stop();

    // R6 segmented transfer longer than the timeout
    to0 = n_to;
    i2c_start(); send(AW, a); send(8'h40, a);
    for (int i = 0; i < 6; i++) send(8'h40 + 8'(i) ^ 8'h3C, a);
    i2c_start(); send(AW, a); send(8'h50, a);
    for (int i = 0; i < 6; i++) begin
      send(8'h50 + 8'(i) ^ 8'h3C, a); chk("R6 ack", a, 1);
    end
    i2c_stop();
    chk("R6 no timeout", n_to - to0, 0);
    rd_one("R6", 8'h42, d); chk("R6 seg1", d, 8'h42 ^ 8'h3C);
    rd_one("R6", 8'h55, d); chk("R6 seg2", d, 8'h55 ^ 8'h3C);

    // R5 long idle after STOP
    to0 = n_to;
    repeat (TOUT + 1500) @(negedge clk);
    chk("R5 halted", n_to - to0, 0);

    // R7 expiry mid transfer
    to0 = n_to;
    i2c_start(); send(AW, a); chk("R7 addr ack", a, 1);
    repeat (TOUT + 500) @(negedge clk);
    chk("R7 one pulse", n_to - to0, 1);
    chk("R7 released", int'(sda_oe), 0);
    send(8'h20, a); chk("R7 ignored ptr", a, 0);
    send(8'h99, a); chk("R7 ignored data", a, 0);
    i2c_stop();
    rd_one("R7", 8'h20, d); chk("R7 unwritten", d, 8'h20 ^ 8'hA5);

    chk("R8 drive on low scl", oe_bad, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule